// File: doc/BRIEF.md
# Single-Cell Bit-Serial Unsigned Multiplier

This block multiplies two unsigned N-bit operands using the least arithmetic hardware possible. One AND gate and one full adder form the whole arithmetic cell. On each clock the cell produces a single 1x1 partial product and adds it into one bit of a running sum. A one-bit carry register feeds the carry back into the cell. Registers hold the operands and the partial sum between cycles.

The b operand rotates past the cell once for every bit of a, so the cell sweeps an N-bit row once per a bit. The a operand shifts out one bit per row. After the last bit of a row, the row carry becomes the new top bit of the high half. The high half then shifts down, and its lowest bit moves into the low half of the product. The next a bit therefore lands one position higher.

A pulse on start loads the operands when the block is idle. The product is ready N*N cycles later, marked by a one-cycle done pulse. The product output then keeps that value until the next result is written.

Top module: `bitserial_mult`

## Requirements
- R1: When done is high, product equals the unsigned product of the a and b values present at the accepted start, with a and b as N-bit unsigned values and product as a 2N-bit unsigned value.
- R2: done is high for exactly one cycle. It rises on the N*N-th rising clock edge after the edge that accepted start, which is 64 edges for N = 8.
- R3: busy goes high on the edge that accepts start and stays high until done rises. busy is low in the cycle where done is high.
- R4: start is ignored while busy is high. Operand changes or start pulses during a run change neither the result nor the time at which done rises.
- R5: product changes only on the edge that raises done. It keeps its value at every other cycle, including through the following run.
- R6: While rst_n is low, busy and done are low and product is zero. A reset in the middle of a run abandons that run.
- R7: The corner operands give exact results: zero times anything is zero, and all-ones times all-ones is (2^N-1)^2.
- R8: A start held high in the cycle where done is high is accepted, so a new run begins with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply, sampled when idle |
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse when product is updated |
| product | output | 2N | Unsigned result, held between completions |

## Verification
Every run starts at a falling edge with start high for exactly one clock. The bench then counts rising edges until done is seen at a falling edge. The count must be exactly 64 for N = 8, and busy must already be high at the first falling edge after the accept edge. The result and the low busy level are sampled in that same falling-edge slot. Ten edges into the next run, the bench confirms that product still holds the previous result, and one edge after done it confirms that done has dropped. For back-to-back runs, the next start is driven in the done cycle itself, and the edge count must again be 64.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bsm_state_t;
endpackage

// File: rtl/bsm_cell.sv
module bsm_cell (
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);
  logic pp;
  always_comb begin
    pp        = a_bit & b_bit;
    sum_out   = pp ^ sum_in ^ carry_in;
    carry_out = (pp & sum_in) | (pp & carry_in) | (sum_in & carry_in);
  end
endmodule

// File: rtl/bsm_seq.sv
module bsm_seq
  import bsm_pkg::*;
#(
  parameter int N  = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          launch,
  output logic          run,
  output logic          last_col,
  output logic          finish,
  output logic [CW-1:0] col
);
  bsm_state_t    state_q, state_d;
  logic [CW-1:0] col_q, col_d;
  logic [CW-1:0] pass_q, pass_d;
  logic          last_pass;

  always_comb begin
    run       = (state_q == ST_RUN);
    launch    = (state_q == ST_IDLE) && start;
    last_col  = (col_q == CW'(N - 1));
    last_pass = (pass_q == CW'(N - 1));
    finish    = run && last_col && last_pass;
    col       = col_q;

    state_d = state_q;
    col_d   = col_q;
    pass_d  = pass_q;
    if (launch) begin
      state_d = ST_RUN;
      col_d   = '0;
      pass_d  = '0;
    end else if (run) begin
      if (last_col) begin
        col_d  = '0;
        pass_d = pass_q + 1'b1;
        if (last_pass) state_d = ST_IDLE;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      pass_q  <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      pass_q  <= pass_d;
    end
  end
endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath #(
  parameter int N  = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1,
  localparam int PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          run,
  input  logic          last_col,
  input  logic          finish,
  input  logic [CW-1:0] col,
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  output logic [PW-1:0] product
);
  logic [N-1:0]  a_q, a_d, b_q, b_d, hi_q, hi_d, lo_q, lo_d, hi_upd;
  logic          cy_q, cy_d, cell_sum, cell_cy, prod_en;
  logic [PW-1:0] prod_q, prod_d;

  bsm_cell u_cell (
    .a_bit    (a_q[0]),
    .b_bit    (b_q[0]),
    .sum_in   (hi_q[col]),
    .carry_in (cy_q),
    .sum_out  (cell_sum),
    .carry_out(cell_cy)
  );

  always_comb begin
    hi_upd      = hi_q;
    hi_upd[col] = cell_sum;

    a_d  = a_q;
    b_d  = b_q;
    hi_d = hi_q;
    lo_d = lo_q;
    cy_d = cy_q;
    if (launch) begin
      a_d  = a;
      b_d  = b;
      hi_d = '0;
      lo_d = '0;
      cy_d = 1'b0;
    end else if (run) begin
      b_d = {b_q[0], b_q[N-1:1]};
      if (last_col) begin
        hi_d = {cell_cy, hi_upd[N-1:1]};
        lo_d = {hi_upd[0], lo_q[N-1:1]};
        cy_d = 1'b0;
        a_d  = a_q >> 1;
      end else begin
        hi_d = hi_upd;
        cy_d = cell_cy;
      end
    end
    prod_en = finish;
    prod_d  = {hi_d, lo_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      hi_q <= '0;
      lo_q <= '0;
      cy_q <= 1'b0;
    end else begin
      a_q  <= a_d;
      b_q  <= b_d;
      hi_q <= hi_d;
      lo_q <= lo_d;
      cy_q <= cy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prod_q <= '0;
    else if (prod_en) prod_q <= prod_d;
  end

  assign product = prod_q;
endmodule

// File: rtl/bitserial_mult.sv
module bitserial_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic          launch, run, last_col, finish, done_q;
  logic [CW-1:0] col;

  bsm_seq #(.N(N)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .launch  (launch),
    .run     (run),
    .last_col(last_col),
    .finish  (finish),
    .col     (col)
  );

  bsm_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .run     (run),
    .last_col(last_col),
    .finish  (finish),
    .col     (col),
    .a       (a),
    .b       (b),
    .product (product)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign busy = run;
  assign done = done_q;
endmodule

// File: rtl/bitserial_mult_chk.sv
module bitserial_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  localparam int KW = $clog2(N * N) + 2;

  logic [2*N-1:0] exp_q;
  logic [KW-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      exp_q <= {{N{1'b0}}, a} * {{N{1'b0}}, b};
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r1_product_value: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == exp_q);
  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt_q == KW'(N * N));
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  a_r5_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
endmodule

bind bitserial_mult bitserial_mult_chk #(.N(N)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .a      (a),
  .b      (b),
  .busy   (busy),
  .done   (done),
  .product(product)
);

// File: tb/bitserial_mult_tb.sv
`timescale 1ns/1ps
module bitserial_mult_tb;
  localparam int N  = 8;
  localparam int NV = 8;
  localparam logic [2*N-1:0] VEC [NV] = '{
    16'h0000, 16'hFFFF, 16'h01FF, 16'hFF01,
    16'h8080, 16'h0D0B, 16'h00FF, 16'hAA55
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   a = '0;
  logic [N-1:0]   b = '0;
  logic           busy, done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bitserial_mult #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_mul(input logic [N-1:0] xa, input logic [N-1:0] xb,
                        input bit meddle, input bit tail);
    logic [2*N-1:0] old;
    logic [2*N-1:0] want;
    int n;
    old  = product;
    want = {{N{1'b0}}, xa} * {{N{1'b0}}, xb};
    a = xa; b = xb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after accept", busy, 1);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (meddle && n == 5) begin start = 1'b1; a = ~xa; b = 8'd3; end
      if (meddle && n == 7) start = 1'b0;
      if (n == 10) chk(product == old, "R5 product held during run", product, old);
      if (done) break;
      if (n > 300) begin
        chk(1'b0, "R2 done never rose", n, N * N);
        break;
      end
    end
    chk(n == N * N, "R2 done latency", n, N * N);
    chk(product == want, meddle ? "R4 result unaffected by start" : "R1 product value",
        product, want);
    chk(busy == 1'b0, "R3 busy low at done", busy, 0);
    if (tail) begin
      @(negedge clk);
      chk(done == 1'b0, "R2 done single cycle", done, 0);
      chk(product == want, "R5 product held after done", product, want);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R6 busy in reset", busy, 0);
    chk(done == 1'b0, "R6 done in reset", done, 0);
    chk(product == '0, "R6 product in reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_mul(VEC[i][2*N-1:N], VEC[i][N-1:0], 1'b0, 1'b1);  // R1, R7 corners
      @(negedge clk);
    end

    for (int i = 0; i < 20; i++) begin
      do_mul(N'($urandom), N'($urandom), 1'b0, 1'b1);      // R1 random
    end

    do_mul(8'd200, 8'd199, 1'b1, 1'b1);                    // R4
    do_mul(8'd0, 8'd255, 1'b0, 1'b0);                      // R7 zero
    do_mul(8'd255, 8'd255, 1'b0, 1'b0);                    // R8 back-to-back
    do_mul(8'd17, 8'd29, 1'b0, 1'b1);                      // R8 back-to-back

    a = 8'd99; b = 8'd77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R6 busy after mid-run reset", busy, 0);
    chk(done == 1'b0, "R6 done after mid-run reset", done, 0);
    chk(product == '0, "R6 product after mid-run reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_mul(8'd123, 8'd45, 1'b0, 1'b1);                     // R1 after reset

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule